// File: doc/BRIEF.md
# Legacy Idle-Level Read Redirection Unit

This unit sits between a core's I/O read path and the external I/O bus. Each I/O read request it accepts is either converted into an internal idle-state request or forwarded to the bus unchanged. A read is converted only when four things hold: redirection is globally enabled, the monitor address has been armed, the read address is one of the idle-level registers placed at fixed offsets from a programmable base, and the level it selects is inside the programmable trap range.

A converted read becomes a single-cycle idle request. The request carries a target state code, a substate that is always zero, and a wake-on-interrupt flag that is always set, so an interrupt wakes the core even while interrupts are masked. A converted read never reaches the bus. Every other read is held in a pass-through register. That register drives the bus request until the bus accepts it with a ready handshake. While a pass-through is pending, the unit does not accept new reads.

Top module: `idle_redirect`

## Requirements
- R1: A trapped read at address `win_base + 4` selects idle level 2. In the cycle after acceptance, it produces `idle_valid` high for exactly one cycle with `idle_state` = 3 (C3).
- R2: A trapped read at address `win_base + 5` selects idle level 3. In the cycle after acceptance, it produces `idle_valid` with `idle_state` = 6 (C6).
- R3: While `redir_en` is 0, every accepted read is forwarded: in the next cycle `io_valid` is 1 with `io_addr` equal to the read address, and `idle_valid` stays 0.
- R4: A trapped read never produces `io_valid`.
- R5: Level L (2 or 3) is trapped only when `range_top` >= L. A read to a level above `range_top` is forwarded as a normal I/O read.
- R6: `idle_sub` is 0 on every idle request.
- R7: `idle_brk` is 1 on every idle request.
- R8: While `mon_armed` is 0, no read is converted, and every read is forwarded.
- R9: A forwarded read keeps `io_valid` high and `io_addr` stable until a cycle with `io_ready` high. `req_ready` is 0 for as long as it is held.
- R10: A read to any address other than `win_base + 4` or `win_base + 5` is forwarded. The offset sum wraps modulo 2^AW.
- R11: After reset, `idle_valid` and `io_valid` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| redir_en | input | 1 | Global redirection enable |
| mon_armed | input | 1 | Monitor address has been configured |
| win_base | input | AW | Base address of the idle-level registers |
| range_top | input | 2 | Highest idle level that is trapped |
| rd_valid | input | 1 | I/O read request strobe |
| rd_addr | input | AW | I/O read address |
| req_ready | output | 1 | Unit can accept a read this cycle |
| io_valid | output | 1 | Forwarded bus I/O read pending |
| io_addr | output | AW | Address of the forwarded read |
| io_ready | input | 1 | Bus accepts the forwarded read |
| idle_valid | output | 1 | One-cycle converted idle request |
| idle_state | output | STW | Target idle-state code (3 = C3, 6 = C6) |
| idle_sub | output | SUBW | Substate, always zero |
| idle_brk | output | 1 | Wake on interrupt even when masked |

## Verification
The assertions assume that `redir_en`, `mon_armed`, `win_base` and `range_top` do not change in the cycle after a read is accepted, because several properties compare the configuration at acceptance against the result one cycle later. They also assume that `rd_addr` is only meaningful when `rd_valid` is high. The stimulus changes configuration only while no read is in flight and only between complete transactions. It drives a read only when `req_ready` is high. It sweeps every combination of enable, armed flag, range and the eight addresses around two base values, one of which forces the offset sum to wrap past the top of the address space.

// File: rtl/idle_redirect_pkg.sv
package idle_redirect_pkg;

   // Idle-state codes delivered on the converted request
   localparam int unsigned CODE_C3 = 3;
   localparam int unsigned CODE_C6 = 6;

   // Lowest idle level that has a register in the window
   localparam int unsigned FIRST_LEVEL = 2;

   // Map an idle level number to the state code it requests
   function automatic int unsigned level_code(input int unsigned lvl);
      return (lvl == FIRST_LEVEL) ? CODE_C3 : CODE_C6;
   endfunction

endpackage

// File: rtl/idle_addr_decode.sv
module idle_addr_decode #(
   parameter int unsigned AW        = 16,
   parameter int unsigned STW       = 4,
   parameter int unsigned NLVL      = 2,
   parameter int unsigned FIRST_OFF = 4
) (
   input  logic [AW-1:0]  addr,
   input  logic [AW-1:0]  base,
   input  logic [1:0]     range_top,
   input  logic           en,
   input  logic           armed,
   output logic           hit,
   output logic [STW-1:0] hit_state
);
   import idle_redirect_pkg::*;

   if (NLVL < 1 || NLVL > 2) begin : g_bad_nlvl
      $error("idle_addr_decode: NLVL must be 1 or 2");
   end
   if (STW < 3) begin : g_bad_stw
      $error("idle_addr_decode: STW too narrow for state codes");
   end

   logic [NLVL-1:0] lvl_hit;
   logic [STW-1:0]  lvl_code [NLVL];

   for (genvar i = 0; i < NLVL; i++) begin : g_lvl
      localparam int unsigned LEVEL = FIRST_LEVEL + i;
      localparam logic [AW-1:0] OFFS = AW'(FIRST_OFF + i);
      logic addr_eq;
      logic in_range;
      assign addr_eq     = (addr == (base + OFFS));
      assign in_range    = (int'(range_top) >= int'(LEVEL));
      assign lvl_hit[i]  = addr_eq && in_range;
      assign lvl_code[i] = STW'(level_code(LEVEL));
   end

   logic           any_hit;
   logic [STW-1:0] sel_code;

   always_comb begin
      any_hit  = 1'b0;
      sel_code = '0;
      for (int k = 0; k < NLVL; k++) begin
         if (lvl_hit[k]) begin
            any_hit  = 1'b1;
            sel_code = lvl_code[k];
         end
      end
   end

   assign hit       = en && armed && any_hit;
   assign hit_state = sel_code;

endmodule

// File: rtl/idle_req_gen.sv
module idle_req_gen #(
   parameter int unsigned STW  = 4,
   parameter int unsigned SUBW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire,
   input  logic [STW-1:0]  fire_state,
   output logic            req_valid,
   output logic [STW-1:0]  req_state,
   output logic [SUBW-1:0] req_sub,
   output logic            req_brk
);

   if (SUBW < 1) begin : g_bad_subw
      $error("idle_req_gen: SUBW must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_state <= '0;
         req_brk   <= 1'b0;
      end else begin
         req_valid <= fire;
         req_brk   <= fire;
         if (fire) begin
            req_state <= fire_state;
         end
      end
   end

   // Legacy reads cannot express a substate
   assign req_sub = '0;

endmodule

// File: rtl/io_pass_hold.sv
module io_pass_hold #(
   parameter int unsigned AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic          bus_ready,
   output logic          bus_valid,
   output logic [AW-1:0] bus_addr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_valid <= 1'b0;
         bus_addr  <= '0;
      end else if (load) begin
         bus_valid <= 1'b1;
         bus_addr  <= load_addr;
      end else if (bus_ready) begin
         bus_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/idle_redirect.sv
module idle_redirect #(
   parameter int unsigned AW        = 16,
   parameter int unsigned STW       = 4,
   parameter int unsigned SUBW      = 4,
   parameter int unsigned NLVL      = 2,
   parameter int unsigned FIRST_OFF = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            redir_en,
   input  logic            mon_armed,
   input  logic [AW-1:0]   win_base,
   input  logic [1:0]      range_top,
   input  logic            rd_valid,
   input  logic [AW-1:0]   rd_addr,
   output logic            req_ready,
   output logic            io_valid,
   output logic [AW-1:0]   io_addr,
   input  logic            io_ready,
   output logic            idle_valid,
   output logic [STW-1:0]  idle_state,
   output logic [SUBW-1:0] idle_sub,
   output logic            idle_brk
);

   if (AW < 4) begin : g_bad_aw
      $error("idle_redirect: AW must be at least 4");
   end

   logic           accept;
   logic           trap;
   logic [STW-1:0] trap_state;

   assign req_ready = !io_valid;
   assign accept    = rd_valid && req_ready;

   idle_addr_decode #(
      .AW(AW), .STW(STW), .NLVL(NLVL), .FIRST_OFF(FIRST_OFF)
   ) u_dec (
      .addr(rd_addr), .base(win_base), .range_top(range_top),
      .en(redir_en), .armed(mon_armed),
      .hit(trap), .hit_state(trap_state)
   );

   idle_req_gen #(
      .STW(STW), .SUBW(SUBW)
   ) u_gen (
      .clk(clk), .rst_n(rst_n),
      .fire(accept && trap), .fire_state(trap_state),
      .req_valid(idle_valid), .req_state(idle_state),
      .req_sub(idle_sub), .req_brk(idle_brk)
   );

   io_pass_hold #(
      .AW(AW)
   ) u_pass (
      .clk(clk), .rst_n(rst_n),
      .load(accept && !trap), .load_addr(rd_addr),
      .bus_ready(io_ready),
      .bus_valid(io_valid), .bus_addr(io_addr)
   );

endmodule

// File: rtl/idle_redirect_chk.sv
module idle_redirect_chk #(
   parameter int unsigned AW        = 16,
   parameter int unsigned STW       = 4,
   parameter int unsigned SUBW      = 4,
   parameter int unsigned NLVL      = 2,
   parameter int unsigned FIRST_OFF = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            redir_en,
   input logic            mon_armed,
   input logic [AW-1:0]   win_base,
   input logic [1:0]      range_top,
   input logic            rd_valid,
   input logic [AW-1:0]   rd_addr,
   input logic            req_ready,
   input logic            io_valid,
   input logic [AW-1:0]   io_addr,
   input logic            io_ready,
   input logic            idle_valid,
   input logic [STW-1:0]  idle_state,
   input logic [SUBW-1:0] idle_sub,
   input logic            idle_brk
);
   logic acc;
   assign acc = rd_valid && req_ready;

   logic gate_ok;
   assign gate_ok = redir_en && mon_armed;

   p_c3_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc && gate_ok && (range_top >= 2'd2) && (rd_addr == win_base + AW'(FIRST_OFF))
      |=> idle_valid && (idle_state == STW'(3)));

   if (NLVL > 1) begin : g_c6
      p_c6_r2: assert property (@(posedge clk) disable iff (!rst_n)
         acc && gate_ok && (range_top == 2'd3) && (rd_addr == win_base + AW'(FIRST_OFF + 1))
         |=> idle_valid && (idle_state == STW'(6)));
   end

   p_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !redir_en |=> io_valid && !idle_valid && (io_addr == $past(rd_addr)));

   p_no_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
      idle_valid |-> !io_valid);

   p_sub_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      idle_valid |-> (idle_sub == '0));

   p_brk_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      idle_valid |-> idle_brk);

   p_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !mon_armed |=> io_valid && !idle_valid);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      io_valid && !io_ready |=> io_valid && $stable(io_addr));

   p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      io_valid |-> !req_ready);

endmodule

bind idle_redirect idle_redirect_chk #(
   .AW(AW), .STW(STW), .SUBW(SUBW), .NLVL(NLVL), .FIRST_OFF(FIRST_OFF)
) u_chk (.*);

// File: tb/sim_idle_redirect.sv
module sim_idle_redirect;
   localparam int unsigned AW   = 16;
   localparam int unsigned STW  = 4;
   localparam int unsigned SUBW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            redir_en = 1'b0;
   logic            mon_armed = 1'b0;
   logic [AW-1:0]   win_base = '0;
   logic [1:0]      range_top = '0;
   logic            rd_valid = 1'b0;
   logic [AW-1:0]   rd_addr = '0;
   logic            req_ready;
   logic            io_valid;
   logic [AW-1:0]   io_addr;
   logic            io_ready = 1'b0;
   logic            idle_valid;
   logic [STW-1:0]  idle_state;
   logic [SUBW-1:0] idle_sub;
   logic            idle_brk;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   idle_redirect u0 (
      .clk(clk), .rst_n(rst_n), .redir_en(redir_en), .mon_armed(mon_armed),
      .win_base(win_base), .range_top(range_top),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .req_ready(req_ready),
      .io_valid(io_valid), .io_addr(io_addr), .io_ready(io_ready),
      .idle_valid(idle_valid), .idle_state(idle_state),
      .idle_sub(idle_sub), .idle_brk(idle_brk)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   // One read transaction with an arithmetically computed expectation
   task automatic do_read(input logic [AW-1:0] base, input int off,
                          input bit en, input bit armed, input int rng);
      logic [AW-1:0] a;
      int lvl;
      bit trap;
      int code;
      string why;
      a    = base + AW'(off);
      lvl  = (off == 4) ? 2 : ((off == 5) ? 3 : 0);
      trap = en && armed && (lvl != 0) && (rng >= lvl);
      code = (lvl == 2) ? 3 : 6;
      if (!en)           why = "R3";
      else if (!armed)   why = "R8";
      else if (lvl != 0) why = "R5";
      else               why = "R10";

      @(negedge clk);
      chk(req_ready == 1'b1, "R9", "ready before read", 32'(req_ready), 32'd1);
      rd_valid = 1'b1;
      rd_addr  = a;
      @(negedge clk);
      rd_valid = 1'b0;
      if (trap) begin
         chk(idle_valid == 1'b1, (lvl == 2) ? "R1" : "R2", "idle pulse",
             32'(idle_valid), 32'd1);
         chk(idle_state == STW'(code), (lvl == 2) ? "R1" : "R2", "state code",
             32'(idle_state), 32'(code));
         chk(idle_sub == '0, "R6", "substate", 32'(idle_sub), 32'd0);
         chk(idle_brk == 1'b1, "R7", "break flag", 32'(idle_brk), 32'd1);
         chk(io_valid == 1'b0, "R4", "no bus read", 32'(io_valid), 32'd0);
         @(negedge clk);
         chk(idle_valid == 1'b0, "R1", "pulse one cycle", 32'(idle_valid), 32'd0);
         chk(io_valid == 1'b0, "R4", "no late bus read", 32'(io_valid), 32'd0);
      end else begin
         chk(idle_valid == 1'b0, why, "no idle request", 32'(idle_valid), 32'd0);
         chk(io_valid == 1'b1, why, "forwarded", 32'(io_valid), 32'd1);
         chk(io_addr == a, why, "forwarded address", 32'(io_addr), 32'(a));
         for (int h = 0; h < (off % 3); h++) begin
            @(negedge clk);
            chk(io_valid == 1'b1 && io_addr == a, "R9", "held request",
                32'(io_addr), 32'(a));
            chk(req_ready == 1'b0, "R9", "stalled while held", 32'(req_ready), 32'd0);
         end
         io_ready = 1'b1;
         @(negedge clk);
         io_ready = 1'b0;
         chk(io_valid == 1'b0, "R9", "released after ready", 32'(io_valid), 32'd0);
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=done");
         finish_run();
      end
   end

   initial begin
      logic [AW-1:0] bases [2];
      bases[0] = 16'h0400;
      bases[1] = 16'hFFFC;
      repeat (3) @(negedge clk);
      chk(idle_valid == 1'b0, "R11", "reset idle_valid", 32'(idle_valid), 32'd0);
      chk(io_valid == 1'b0, "R11", "reset io_valid", 32'(io_valid), 32'd0);
      chk(req_ready == 1'b1, "R11", "reset req_ready", 32'(req_ready), 32'd1);
      rst_n = 1'b1;
      for (int b = 0; b < 2; b++) begin
         for (int e = 0; e < 2; e++) begin
            for (int m = 0; m < 2; m++) begin
               for (int r = 0; r < 4; r++) begin
                  @(negedge clk);
                  win_base  = bases[b];
                  redir_en  = e[0];
                  mon_armed = m[0];
                  range_top = r[1:0];
                  for (int o = 0; o < 8; o++) begin
                     do_read(bases[b], o, e[0], m[0], r);
                  end
               end
            end
         end
      end
      finished = 1'b1;
      finish_run();
   end

endmodule